// File: doc/BRIEF.md
# Deskew Training Pattern Generator

This block sits on the transmit side of a multi-lane serial link. On every clock it produces one 7-bit frame for the clock lane and one 7-bit frame for each data lane. A serializer outside this block shifts each frame out most significant bit first. In normal operation the clock lane carries a square-like frame, and each data lane carries its payload frame unchanged.

When link training is requested, the block changes the shape of the clock-lane frame so that the far end can tell it is in training mode. It also replaces every data lane with a clock-like calibration frame, which the receiver uses to tune its sampling point for each lane. The training request input is active low. It is honoured only while balanced-coding mode is on; otherwise it has no effect. A done flag rises once the request has held long enough for the receiver to finish calibrating.

All outputs are registered. Each output frame is decided whole, from the inputs sampled at one clock edge, so no frame mixes two patterns.

Top module: `deskew_pattern_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, the clock-lane frame is 7'b1111000, every data frame is 7'b0000000 and the done flag is 0.
- R2: Outside training, one clock edge after sampling, the clock-lane frame is 7'b1111000 when the variant select is 0 and 7'b1110000 when it is 1.
- R3: Outside training, each data lane's output frame equals the payload frame sampled at the previous edge. Lane i occupies bits [7i+6:7i] of both the payload bus and the data output bus.
- R4: In training (request low and balance mode on at the edge), the clock-lane frame becomes 7'b1111100 for variant 0 and 7'b1100000 for variant 1.
- R5: In training, every data lane carries 7'b1111000 for variant 0 and 7'b1110000 for variant 1, whatever the payload.
- R6: With balance mode off, a low training request has no effect: the clock-lane frame follows R2 and the data lanes follow R3.
- R7: The done flag rises after the fourth consecutive clock edge that samples training, counting with MIN_TRAIN = 4. It stays high for as long as training continues.
- R8: An edge that samples no training clears the done flag and restarts the count, so a burst of three training edges never raises the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Frame clock |
| rst_i | input | 1 | Synchronous reset, active high |
| train_req_n_i | input | 1 | Training request, active low |
| bal_en_i | input | 1 | Balance mode enable; training is honoured only when high |
| var_sel_i | input | 1 | Pattern variant select (0 = four-high frames, 1 = three-high frames) |
| payload_i | input | NUM_LANES*7 | Payload frames, lane i in bits [7i+6:7i] |
| clk_frame_o | output | 7 | Clock-lane frame, MSB sent first |
| data_frames_o | output | NUM_LANES*7 | Data-lane frames, lane i in bits [7i+6:7i] |
| train_done_o | output | 1 | Minimum training length reached |

## Verification
The bench builds the block with its defaults: eight lanes and a minimum training length of four. With these values the done threshold is reached in only a few cycles, so random bursts of training often cross it, stop just short of it, or get cut off by balance mode being turned off. The eight-lane width puts every calibration frame at its own position on a bus wide enough to catch lane-slicing errors. Directed sequences cover the three-edge burst, exactly four edges, a held burst, and a request made while balance mode is off, in both variants.

// File: rtl/dtpg_pkg.sv
package dtpg_pkg;

    localparam int FRAME_W = 7;

    typedef logic [FRAME_W-1:0] frame_t;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_TRAIN  = 1'b1
    } lane_mode_e;

    typedef enum logic {
        VAR_WIDE   = 1'b0,
        VAR_NARROW = 1'b1
    } pat_var_e;

    typedef struct packed {
        lane_mode_e mode;
        pat_var_e   variant;
    } frame_sel_t;

    localparam frame_t RUN_WIDE     = 7'b1111000;
    localparam frame_t RUN_NARROW   = 7'b1110000;
    localparam frame_t MARK_WIDE    = 7'b1111100;
    localparam frame_t MARK_NARROW  = 7'b1100000;

    function automatic frame_t clk_pattern(frame_sel_t s);
        if (s.mode == MODE_TRAIN)
            return (s.variant == VAR_WIDE) ? MARK_WIDE : MARK_NARROW;
        return (s.variant == VAR_WIDE) ? RUN_WIDE : RUN_NARROW;
    endfunction

    function automatic frame_t cal_pattern(pat_var_e v);
        return (v == VAR_WIDE) ? RUN_WIDE : RUN_NARROW;
    endfunction

endpackage

// File: rtl/dtpg_mode_ctrl.sv
module dtpg_mode_ctrl
    import dtpg_pkg::*;
#(
    parameter int MIN_TRAIN = 4
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       train_req_n_i,
    input  logic       bal_en_i,
    input  logic       var_sel_i,
    output frame_sel_t sel_o,
    output logic       done_o
);
    localparam int CNT_W = $clog2(MIN_TRAIN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_TRAIN);

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        sel_o.mode    = (bal_en_i && !train_req_n_i) ? MODE_TRAIN : MODE_NORMAL;
        sel_o.variant = pat_var_e'(var_sel_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)
            cnt_q <= '0;
        else if (sel_o.mode != MODE_TRAIN)
            cnt_q <= '0;
        else if (cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = (cnt_q == CNT_MAX);

    // R8: a non-training edge always leaves done low
    assert_done_clears_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_o.mode != MODE_TRAIN) |=> !done_o);

    // R7: done holds while training continues
    assert_done_holds_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && sel_o.mode == MODE_TRAIN) |=> done_o);

endmodule

// File: rtl/dtpg_clk_lane.sv
module dtpg_clk_lane
    import dtpg_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  frame_sel_t sel_i,
    output frame_t     frame_o
);
    frame_t frame_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            frame_q <= RUN_WIDE;
        else
            frame_q <= clk_pattern(sel_i);
    end

    assign frame_o = frame_q;

    // R4: training with the wide variant marks the clock lane with five ones
    assert_train_mark_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_i.mode == MODE_TRAIN && sel_i.variant == VAR_WIDE) |=> ($countones(frame_o) == 5));

    // R2: normal framing always carries a leading high run and trailing zeros
    assert_run_shape_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_i.mode == MODE_NORMAL) |=> (frame_o[FRAME_W-1] && !frame_o[0] && $countones(frame_o) >= 3));

endmodule

// File: rtl/dtpg_data_lanes.sv
module dtpg_data_lanes
    import dtpg_pkg::*;
#(
    parameter int NUM_LANES = 8
) (
    input  logic                         clk_i,
    input  logic                         rst_i,
    input  frame_sel_t                   sel_i,
    input  logic [NUM_LANES*FRAME_W-1:0] payload_i,
    output logic [NUM_LANES*FRAME_W-1:0] frames_o
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        frame_t frame_q;
        frame_t pay;

        assign pay = payload_i[g*FRAME_W +: FRAME_W];

        always_ff @(posedge clk_i) begin
            if (rst_i)
                frame_q <= '0;
            else if (sel_i.mode == MODE_TRAIN)
                frame_q <= cal_pattern(sel_i.variant);
            else
                frame_q <= pay;
        end

        assign frames_o[g*FRAME_W +: FRAME_W] = frame_q;

        // R5: a calibration frame starts high and ends low
        assert_cal_shape_R5: assert property (@(posedge clk_i) disable iff (rst_i)
            (sel_i.mode == MODE_TRAIN) |=> (frame_q[FRAME_W-1 -: 3] == 3'b111 && frame_q[2:0] == 3'b000));
    end

endmodule

// File: rtl/deskew_pattern_gen.sv
module deskew_pattern_gen
    import dtpg_pkg::*;
#(
    parameter int NUM_LANES = 8,
    parameter int MIN_TRAIN = 4
) (
    input  logic                         clk_i,
    input  logic                         rst_i,
    input  logic                         train_req_n_i,
    input  logic                         bal_en_i,
    input  logic                         var_sel_i,
    input  logic [NUM_LANES*FRAME_W-1:0] payload_i,
    output logic [FRAME_W-1:0]           clk_frame_o,
    output logic [NUM_LANES*FRAME_W-1:0] data_frames_o,
    output logic                         train_done_o
);
    frame_sel_t sel;

    dtpg_mode_ctrl #(.MIN_TRAIN(MIN_TRAIN)) ctrl_i (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .train_req_n_i (train_req_n_i),
        .bal_en_i      (bal_en_i),
        .var_sel_i     (var_sel_i),
        .sel_o         (sel),
        .done_o        (train_done_o)
    );

    dtpg_clk_lane clk_lane_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .sel_i   (sel),
        .frame_o (clk_frame_o)
    );

    dtpg_data_lanes #(.NUM_LANES(NUM_LANES)) lanes_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .sel_i     (sel),
        .payload_i (payload_i),
        .frames_o  (data_frames_o)
    );

    // R6: without balance mode the payload passes through untouched
    assert_bal_off_pass_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        !bal_en_i |=> (data_frames_o == $past(payload_i)));

    // R3: a high request passes payload through
    assert_normal_pass_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        train_req_n_i |=> (data_frames_o == $past(payload_i)));

endmodule

// File: tb/deskew_pattern_gen_tb.sv
module deskew_pattern_gen_tb_top;
    localparam int LANES = 8;
    localparam int MINT  = 4;
    localparam int W     = 7;

    logic clk = 1'b0;
    logic rst;
    logic train_n, bal, vsel;
    logic [LANES*W-1:0] payload;
    logic [W-1:0]       clk_frame;
    logic [LANES*W-1:0] data_frames;
    logic               done;

    int n_vec = 0;
    int n_bad = 0;
    int exp_cnt = 0;

    always #5 clk = ~clk;

    deskew_pattern_gen #(.NUM_LANES(LANES), .MIN_TRAIN(MINT)) dut_i (
        .clk_i         (clk),
        .rst_i         (rst),
        .train_req_n_i (train_n),
        .bal_en_i      (bal),
        .var_sel_i     (vsel),
        .payload_i     (payload),
        .clk_frame_o   (clk_frame),
        .data_frames_o (data_frames),
        .train_done_o  (done)
    );

    function automatic logic [W-1:0] exp_clk(logic tr, logic v);
        if (tr) return v ? 7'b1100000 : 7'b1111100;
        return v ? 7'b1110000 : 7'b1111000;
    endfunction

    function automatic logic [LANES*W-1:0] exp_data(logic tr, logic v, logic [LANES*W-1:0] p);
        logic [LANES*W-1:0] r;
        if (!tr) return p;
        for (int i = 0; i < LANES; i++)
            r[i*W +: W] = v ? 7'b1110000 : 7'b1111000;
        return r;
    endfunction

    task automatic check(string req, logic [LANES*W-1:0] act, logic [LANES*W-1:0] expv);
        n_vec++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic step(logic tn, logic b, logic v, logic [LANES*W-1:0] p, string tag);
        logic tr;
        @(negedge clk);
        train_n = tn; bal = b; vsel = v; payload = p;
        @(posedge clk);
        #1;
        tr = b && !tn;
        exp_cnt = tr ? ((exp_cnt < MINT) ? exp_cnt + 1 : MINT) : 0;
        check({tag, " clk R2/R4"}, {{(LANES-1)*W{1'b0}}, clk_frame}, {{(LANES-1)*W{1'b0}}, exp_clk(tr, v)});
        check({tag, " data R3/R5/R6"}, data_frames, exp_data(tr, v, p));
        check({tag, " done R7/R8"}, {{(LANES*W-1){1'b0}}, done}, {{(LANES*W-1){1'b0}}, exp_cnt == MINT});
    endtask

    function automatic logic [LANES*W-1:0] rnd_payload();
        logic [LANES*W-1:0] r;
        for (int i = 0; i < LANES; i++) r[i*W +: W] = W'($urandom);
        return r;
    endfunction

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; train_n = 1'b0; bal = 1'b1; vsel = 1'b1; payload = '1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset clk", {{(LANES-1)*W{1'b0}}, clk_frame}, {{(LANES-1)*W{1'b0}}, 7'b1111000});
        check("R1 reset data", data_frames, '0);
        check("R1 reset done", {{(LANES*W-1){1'b0}}, done}, '0);
        @(negedge clk);
        rst = 1'b0; train_n = 1'b1; bal = 1'b0; vsel = 1'b0; payload = '0;
        exp_cnt = 0;
        // R2/R3 normal, both variants
        step(1'b1, 1'b1, 1'b0, rnd_payload(), "R2 R3 var0");
        step(1'b1, 1'b1, 1'b1, rnd_payload(), "R2 R3 var1");
        // R8: three-edge burst never raises done
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, rnd_payload(), "R8 short burst");
        step(1'b1, 1'b1, 1'b0, rnd_payload(), "R8 release");
        // R7: exactly four then held
        for (int i = 0; i < 7; i++) step(1'b0, 1'b1, i[0], rnd_payload(), "R7 R4 R5 burst");
        // R6: request while balance off, count restarts
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, i[0], rnd_payload(), "R6 bal off");
        // R8: balance drop mid-burst
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, rnd_payload(), "R8 pre-drop");
        step(1'b0, 1'b0, 1'b1, rnd_payload(), "R8 drop");
        step(1'b0, 1'b1, 1'b1, rnd_payload(), "R8 restart");
        // random mix, training biased on
        for (int i = 0; i < 400; i++)
            step(($urandom % 4) == 0, ($urandom % 8) != 0, 1'($urandom), rnd_payload(), "random");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule